// File: doc/BRIEF.md
# Serial Parity-Match Detector

This block watches a one-bit serial stream, taking one bit per clock. For each accepted bit it decides whether that bit equals the XOR of the two accepted bits before it. The answer is given in two forms from the same stream. The first is a combinational flag, valid in the same cycle as the bit. The second is a registered flag that gives the same answer one cycle later.

After reset the block passes through a start state and a one-bit warm-up state. While fewer than two bits of history exist, no match is reported. An optional qualifier input marks which cycles carry a real bit. On cycles without a bit, the stored history holds and no match is reported. A parameter removes the qualifier, so that every cycle carries a bit.

Top module: `parity_match_fsm`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, both outputs are 0 in the following cycle, whatever `in_bit` and `in_valid` are.
- R2: Once two bits of history are stored, an accepted bit raises `mealy_out` exactly when it equals the XOR of the two accepted bits before it. For the triple (oldest, previous, current), the output is 1 for 000, 011, 101 and 110, and 0 for 001, 010, 100 and 111.
- R3: For the first and second accepted bits after reset, `mealy_out` is 0 whatever their values.
- R4: `mealy_out` responds to `in_bit` within the same cycle, with no register between them.
- R5: In every cycle after the first cycle out of reset, `moore_out` equals the value `mealy_out` had in the previous cycle.
- R6: With `HAS_VALID` = 1, a cycle with `in_valid` = 0 accepts no bit and leaves the two-bit history unchanged. In that cycle `mealy_out` is 0, and in the next cycle `moore_out` is 0.
- R7: With `HAS_VALID` = 0, `in_valid` has no effect, and a bit is accepted on every cycle.
- R8: A reset in the middle of a stream discards all history, so the warm-up of R3 starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | High when `in_bit` carries a bit (ignored when `HAS_VALID` = 0) |
| in_bit | input | 1 | Serial data bit |
| mealy_out | output | 1 | Combinational match flag for the current bit |
| moore_out | output | 1 | Registered match flag, one cycle behind `mealy_out` |

## Verification
The bench builds two copies of the block side by side and drives both with the same stimulus. One copy uses `HAS_VALID` = 1, which brings gaps in the stream within reach: history must survive idle cycles, and the registered flag must clear after a gap. The other copy uses `HAS_VALID` = 0, where a low qualifier must change nothing. Both copies go through all eight bit triples, long random streams, and resets back to back and in the middle of a stream, so warm-up is exercised many times.

// File: rtl/pmf_pkg.sv
// Shared types and the match rule for the serial parity-match detector.
// Assumes callers pass bits in stream order: oldest, previous, current.
package pmf_pkg;

    typedef enum logic [1:0] {
        PH_START  = 2'd0,  // nothing seen since reset
        PH_ONE    = 2'd1,  // one bit seen
        PH_STEADY = 2'd2   // two or more bits seen
    } phase_e;

    // Match when the current bit equals the XOR of the two before it.
    function automatic logic match_rule(input logic oldest, input logic prev, input logic cur);
        return cur == (oldest ^ prev);
    endfunction

endpackage

// File: rtl/pmf_mealy_core.sv
// Mealy-form detector: the flag is combinational from the stored two-bit
// history and the incoming bit. Assumes take_i marks cycles carrying a bit.
module pmf_mealy_core
    import pmf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic bit_i,
    output logic match_o
);

    phase_e phase_q;
    logic   oldest_q;
    logic   prev_q;

    // Advance the warm-up phase and shift the history on each accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_START;
            oldest_q <= 1'b0;
            prev_q   <= 1'b0;
        end else if (take_i) begin
            oldest_q <= prev_q;
            prev_q   <= bit_i;
            case (phase_q)
                PH_START: phase_q <= PH_ONE;
                default:  phase_q <= PH_STEADY;
            endcase
        end
    end

    // Report a match only for an accepted bit with full history.
    always_comb begin
        match_o = (phase_q == PH_STEADY) && take_i && match_rule(oldest_q, prev_q, bit_i);
    end

endmodule

// File: rtl/pmf_moore_core.sv
// Moore-form detector: the state holds (previous, current, pending flag), and
// the output is the pending flag. Assumes the same take_i qualifier as the
// Mealy core.
module pmf_moore_core
    import pmf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic bit_i,
    output logic flag_o
);

    phase_e phase_q;
    logic   prev_q;
    logic   cur_q;
    logic   pend_q;

    // Shift the history and compute the flag to present next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_START;
            prev_q  <= 1'b0;
            cur_q   <= 1'b0;
            pend_q  <= 1'b0;
        end else if (take_i) begin
            prev_q <= cur_q;
            cur_q  <= bit_i;
            pend_q <= (phase_q == PH_STEADY) && match_rule(prev_q, cur_q, bit_i);
            case (phase_q)
                PH_START: phase_q <= PH_ONE;
                default:  phase_q <= PH_STEADY;
            endcase
        end else begin
            pend_q <= 1'b0;
        end
    end

    // The output is the stored pending flag alone.
    always_comb begin
        flag_o = pend_q;
    end

endmodule

// File: rtl/parity_match_fsm.sv
// Top level of the serial parity-match detector. It feeds one stream to a
// Mealy core and a Moore core. HAS_VALID picks whether in_valid qualifies
// the bits (1) or every cycle carries a bit (0).
module parity_match_fsm #(
    parameter bit HAS_VALID = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic mealy_out,
    output logic moore_out
);

    logic take;

    generate
        if (HAS_VALID) begin : g_qual
            // Accept a bit only when the qualifier is high.
            assign take = in_valid;
        end else begin : g_free
            logic unused_valid;
            // Accept every cycle; the qualifier is left unconnected internally.
            assign unused_valid = in_valid;
            assign take = 1'b1;
        end
    endgenerate

    pmf_mealy_core u_mealy (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .bit_i   (in_bit),
        .match_o (mealy_out)
    );

    pmf_moore_core u_moore (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .bit_i  (in_bit),
        .flag_o (moore_out)
    );

endmodule

// File: rtl/pmf_checker.sv
// Property checker for parity_match_fsm, bound to every instance.
// Assumes it sees the top-level ports and the HAS_VALID setting.
module pmf_checker #(
    parameter bit HAS_VALID = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic mealy_out,
    input logic moore_out
);

    // R1: reset clears the registered flag
    p_reset_clears_r1: assert property (@(posedge clk) !rst_n |=> !moore_out);

    // R3: first bit after reset never matches
    p_warmup_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !mealy_out);

    // R5: registered flag trails the combinational flag by one cycle
    p_moore_trails_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> moore_out == $past(mealy_out));

    // R6: no flag on an idle cycle
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_VALID && !in_valid) |-> !mealy_out);

    // R6: no registered flag after an idle cycle
    p_idle_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_VALID && !in_valid) |=> !moore_out);

endmodule

bind parity_match_fsm pmf_checker #(.HAS_VALID(HAS_VALID)) u_pmf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mealy_out (mealy_out),
    .moore_out (moore_out)
);

// File: tb/parity_match_fsm_bench.sv
module parity_match_fsm_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic mealy_a, moore_a, mealy_b, moore_b;

    int n_cmp = 0;
    int n_bad = 0;

    // model state: bits accepted since reset, and previous expected flags
    int hist_a[$];
    int hist_b[$];
    logic exp_moore_a = 1'b0;
    logic exp_moore_b = 1'b0;

    always #5 clk = ~clk;

    parity_match_fsm #(.HAS_VALID(1'b1)) u_parity_match_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .mealy_out(mealy_a), .moore_out(moore_a));

    parity_match_fsm #(.HAS_VALID(1'b0)) u_parity_match_fsm_nv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .mealy_out(mealy_b), .moore_out(moore_b));

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic ref_flag(input int h[$], input logic take, input logic b);
        if (!take || h.size() < 2) return 1'b0;
        return ((h[h.size()-2] ^ h[h.size()-1]) == int'(b));
    endfunction

    // One cycle: drive after the falling edge, compare, then advance the model.
    task automatic step(input logic r, input logic v, input logic b, input string ctx);
        logic em_a, em_b;
        string ta, tb;
        @(negedge clk);
        rst_n = r; in_valid = v; in_bit = b;
        #2;
        em_a = ref_flag(hist_a, v, b);
        em_b = ref_flag(hist_b, 1'b1, b);
        ta = !v ? "R6" : (hist_a.size() < 2 ? "R3" : "R2");
        tb = hist_b.size() < 2 ? "R3/R7" : "R7";
        check({ta, " mealy ", ctx}, mealy_a, em_a);   // R4: same-cycle response
        check({"R5 moore ", ctx}, moore_a, exp_moore_a);
        check({tb, " mealy nv ", ctx}, mealy_b, em_b);
        check({"R5 moore nv ", ctx}, moore_b, exp_moore_b);
        if (!r) begin
            hist_a.delete(); hist_b.delete();
            exp_moore_a = 1'b0; exp_moore_b = 1'b0;   // R1
        end else begin
            exp_moore_a = em_a; exp_moore_b = em_b;
            if (v) hist_a.push_back(int'(b));
            hist_b.push_back(int'(b));
            if (hist_a.size() > 2) void'(hist_a.pop_front());
            if (hist_b.size() > 2) void'(hist_b.pop_front());
        end
        @(posedge clk);
    endtask

    initial begin
        // R1: hold reset with noisy inputs
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, i[0], "R1 reset");
        // R2: every triple, each after a fresh reset
        for (int t = 0; t < 8; t++) begin
            step(1'b0, 1'b0, 1'b0, "R8 reset");
            step(1'b1, 1'b1, t[2], "R3 first");
            step(1'b1, 1'b1, t[1], "R3 second");
            step(1'b1, 1'b1, t[0], "R2 triple");
        end
        // R6: gaps inside a stream keep history
        step(1'b1, 1'b0, 1'b1, "R6 gap");
        step(1'b1, 1'b0, 1'b0, "R6 gap");
        step(1'b1, 1'b1, 1'b1, "R6 after gap");
        // random streams with gaps and resets
        for (int i = 0; i < 3000; i++) begin
            logic r, v;
            r = ($urandom_range(0, 49) != 0);
            v = ($urandom_range(0, 4) != 0);
            step(r, v, 1'($urandom_range(0, 1)), "R8 random");
        end
        // R8: back-to-back resets then immediate stream
        step(1'b0, 1'b1, 1'b1, "R8 reset");
        step(1'b0, 1'b1, 1'b0, "R8 reset");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'(i % 3 == 2), "R8 restart");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule